// File: doc/BRIEF.md
# Indirect-Programmed Multi-Channel DMA Register Front End

This block holds the per-channel setup for a 16-channel DMA controller. The host reaches it through two byte-wide ports. A write to the command port names an operation in the upper nibble and a channel in the lower nibble. The data port then moves the parameter bytes of that operation, one byte per access. An internal byte pointer tracks which byte comes next.

Each channel keeps the following state:
- a 24-bit memory address
- a 16-bit transfer count, programmed as the number of units minus one
- a 16-bit I/O port number
- a mode byte
- a mask bit

A transfer-enable output is raised for every channel that is unmasked and has its mode transfer bit set. The transfer engine uses this output together with the exported per-channel settings. The engine pulses a decrement strobe with a channel number for each unit it moves. On that strobe the count steps down, and the address steps down by the unit size.

The usual setup order for a channel is:
1. Mask it.
2. Write its mode.
3. Write its address.
4. Write its count, set to the length in units minus one. In 16-bit mode the unit is a word, so an even byte length is halved.
5. Unmask it.

A single transfer covers up to 65536 units in one contiguous block. There is no boundary restriction.

Top module: `dma_cmd_port_ctrl`

## Requirements
- R1: After reset every channel is masked, and every mode, address, count and I/O port register is zero. Every transfer-enable bit is 0.
- R2: A command byte selects the channel from bits 3:0 and the operation from bits 7:4. Every command write returns the parameter byte pointer to zero. A data-port access in the same cycle as a command write is discarded.
- R3: After operation 0x2 (set address), three data writes load address bits 7:0, 15:8 and 23:16, in that order.
- R4: After operation 0x4 (set count), two data writes load count bits 7:0 and then 15:8. The value is the unit count minus one.
- R5: After operation 0x0 (set I/O port), two data writes load port bits 7:0 and then 15:8.
- R6: After operation 0x7 (set mode), one data write loads the mode byte. The mode bits mean:
  - bit 2: transfer enable
  - bit 3: read (1) or write (0)
  - bit 0: I/O-port target
  - bit 6: 16-bit units
- R7: Operation 0x9 sets the channel's mask and operation 0xA clears it. A channel's transfer-enable bit is high exactly when that channel is unmasked and mode bit 2 is set.
- R8: Operation 0xD sets every channel's mask and clears every mode byte. Addresses and counts are left unchanged.
- R9: After operation 0x3 (read address), `dat_rdata` presents address bits 7:0, then 15:8, then 23:16. Each `dat_rd` pulse advances to the next byte. Operation 0x5 (read count) does the same with count bits 7:0 and then 15:8.
- R10: After operation 0x6 (read status), `dat_rdata` presents one byte:
  - bit 0: mask
  - bit 1: count is zero
  - bit 2: transfer enable
  - all other bits are 0
- R11: The following data accesses change no state and do not advance the pointer:
  - accesses beyond the last byte of the current operation
  - data writes under a read operation
  - data reads under a write operation
  - any data access under a mask, unmask, clear or unknown operation

  `dat_rdata` is 0 whenever no read byte is pending.
- R12: A decrement strobe on a channel with a non-zero count lowers the count by 1. It lowers the address by 1, or by 2 when mode bit 6 is set, wrapping modulo 2^24. On a channel whose count is zero the strobe has no effect.
- R13: If a data write lands on a channel in the same cycle as a decrement strobe for that channel, the write takes effect and that decrement is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command-port write strobe |
| cmd_byte | input | 8 | Command byte: operation in 7:4, channel in 3:0 |
| dat_wr | input | 1 | Data-port write strobe |
| dat_wdata | input | 8 | Data-port write byte |
| dat_rd | input | 1 | Data-port read strobe; advances the read pointer |
| dat_rdata | output | 8 | Data-port read byte for the current pointer |
| dec_valid | input | 1 | Decrement strobe from the transfer engine |
| dec_chan | input | 4 | Channel being decremented |
| xfer_en | output | 16 | Per-channel transfer enable |
| ch_addr | output | 384 | Channel addresses, channel n at bits 24n+23:24n |
| ch_count | output | 256 | Channel counts, channel n at bits 16n+15:16n |
| ch_ioport | output | 256 | Channel I/O ports, channel n at bits 16n+15:16n |
| ch_mode | output | 128 | Channel mode bytes, channel n at bits 8n+7:8n |

## Verification
Every register update is due one clock edge after its strobe. This covers command effects, data-byte loads, mask changes and decrements. `dat_rdata` is combinational from registered state, so it is valid from the first edge after the command write and changes only on the edge that takes a `dat_rd`. The bench drives each strobe at a falling edge and drops it at the next one. It samples the exported registers, the transfer-enable bits and `dat_rdata` at that next falling edge, half a period after the edge that made the change, and before any further strobe.

// File: rtl/dma_cmd_pkg.sv
package dma_cmd_pkg;

  typedef enum logic [3:0] {
    OP_SET_IO   = 4'h0,
    OP_SET_ADDR = 4'h2,
    OP_GET_ADDR = 4'h3,
    OP_SET_CNT  = 4'h4,
    OP_GET_CNT  = 4'h5,
    OP_GET_STAT = 4'h6,
    OP_SET_MODE = 4'h7,
    OP_MASK     = 4'h9,
    OP_UNMASK   = 4'hA,
    OP_CLEAR    = 4'hD,
    OP_NONE     = 4'hF
  } op_e;

  localparam int MODE_IO   = 0;
  localparam int MODE_XFER = 2;
  localparam int MODE_READ = 3;
  localparam int MODE_WIDE = 6;

  // Map a raw nibble to an operation; unused codes become OP_NONE.
  function automatic op_e decode_op(input logic [3:0] nib);
    case (nib)
      4'h0: return OP_SET_IO;
      4'h2: return OP_SET_ADDR;
      4'h3: return OP_GET_ADDR;
      4'h4: return OP_SET_CNT;
      4'h5: return OP_GET_CNT;
      4'h6: return OP_GET_STAT;
      4'h7: return OP_SET_MODE;
      4'h9: return OP_MASK;
      4'hA: return OP_UNMASK;
      4'hD: return OP_CLEAR;
      default: return OP_NONE;
    endcase
  endfunction

  // Number of data-port bytes an operation moves.
  function automatic logic [2:0] param_bytes(input op_e op, input logic [2:0] ab,
                                             input logic [2:0] cb, input logic [2:0] pb);
    case (op)
      OP_SET_IO:   return pb;
      OP_SET_ADDR,
      OP_GET_ADDR: return ab;
      OP_SET_CNT,
      OP_GET_CNT:  return cb;
      OP_GET_STAT,
      OP_SET_MODE: return 3'd1;
      default:     return 3'd0;
    endcase
  endfunction

  function automatic logic is_write_op(input op_e op);
    return (op == OP_SET_IO) || (op == OP_SET_ADDR) ||
           (op == OP_SET_CNT) || (op == OP_SET_MODE);
  endfunction

  function automatic logic is_read_op(input op_e op);
    return (op == OP_GET_ADDR) || (op == OP_GET_CNT) || (op == OP_GET_STAT);
  endfunction

endpackage

// File: rtl/dma_cmd_decoder.sv
module dma_cmd_decoder
  import dma_cmd_pkg::*;
#(
  parameter int NCH = 16,
  parameter int AB  = 3,
  parameter int CB  = 2,
  parameter int PB  = 2,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_wr,
  input  logic [7:0]     cmd_byte,
  input  logic           dat_wr,
  input  logic           dat_rd,
  output op_e            op_q,
  output logic [CHW-1:0] chan_q,
  output logic [2:0]     ptr_q,
  output logic [CHW-1:0] cmd_chan,
  output logic           wr_ev,
  output logic           rd_ev,
  output logic           mask_ev,
  output logic           unmask_ev,
  output logic           clr_ev
);

  op_e        cmd_op;
  logic [2:0] limit;
  logic       slot_open;

  assign cmd_op    = decode_op(cmd_byte[7:4]);
  assign cmd_chan  = cmd_byte[CHW-1:0];
  assign limit     = param_bytes(op_q, 3'(AB), 3'(CB), 3'(PB));
  assign slot_open = !cmd_wr && (ptr_q < limit);

  assign wr_ev     = dat_wr && slot_open && is_write_op(op_q);
  assign rd_ev     = dat_rd && slot_open && is_read_op(op_q);
  assign mask_ev   = cmd_wr && (cmd_op == OP_MASK);
  assign unmask_ev = cmd_wr && (cmd_op == OP_UNMASK);
  assign clr_ev    = cmd_wr && (cmd_op == OP_CLEAR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= OP_NONE;
      chan_q <= '0;
      ptr_q  <= '0;
    end else if (cmd_wr) begin
      op_q   <= cmd_op;
      chan_q <= cmd_chan;
      ptr_q  <= '0;
    end else if (wr_ev || rd_ev) begin
      ptr_q  <= ptr_q + 3'd1;
    end
  end

  AST_CMD_CLEARS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> (ptr_q == 3'd0)); // R2
  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= limit); // R11
  AST_IDLE_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_wr && !wr_ev && !rd_ev) |=> $stable(ptr_q)); // R11

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_cmd_pkg::*;
#(
  parameter int AW = 24,
  parameter int CW = 16,
  parameter int PW = 16,
  localparam int AB = AW / 8,
  localparam int CB = CW / 8,
  localparam int PB = PW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_dat,
  input  logic          sel_cmd,
  input  op_e           op,
  input  logic          wr_ev,
  input  logic [2:0]    wr_idx,
  input  logic [7:0]    wdata,
  input  logic          mask_ev,
  input  logic          unmask_ev,
  input  logic          clr_ev,
  input  logic          dec,
  output logic [AW-1:0] addr,
  output logic [CW-1:0] count,
  output logic [PW-1:0] ioport,
  output logic [7:0]    mode,
  output logic          mask,
  output logic          xen
);

  logic take_wr;
  logic dec_ok;

  function automatic logic [AW-1:0] unit_step(input logic wide);
    return wide ? AW'(2) : AW'(1);
  endfunction

  assign take_wr = sel_dat && wr_ev;
  assign dec_ok  = dec && !take_wr && (count != '0);
  assign xen     = !mask && mode[MODE_XFER];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr   <= '0;
      count  <= '0;
      ioport <= '0;
    end else if (take_wr) begin
      case (op)
        OP_SET_ADDR: for (int b = 0; b < AB; b++)
                       if (wr_idx == 3'(b)) addr[b*8 +: 8] <= wdata;
        OP_SET_CNT:  for (int b = 0; b < CB; b++)
                       if (wr_idx == 3'(b)) count[b*8 +: 8] <= wdata;
        OP_SET_IO:   for (int b = 0; b < PB; b++)
                       if (wr_idx == 3'(b)) ioport[b*8 +: 8] <= wdata;
        default: ;
      endcase
    end else if (dec_ok) begin
      count <= count - CW'(1);
      addr  <= addr - unit_step(mode[MODE_WIDE]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= '0;
      mask <= 1'b1;
    end else if (clr_ev) begin
      mode <= '0;
      mask <= 1'b1;
    end else begin
      if (take_wr && op == OP_SET_MODE) mode <= wdata;
      if (sel_cmd && mask_ev) mask <= 1'b1;
      else if (sel_cmd && unmask_ev) mask <= 1'b0;
    end
  end

  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    dec_ok |=> (count == $past(count) - CW'(1))); // R12
  AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !take_wr && count == '0) |=> ($stable(count) && $stable(addr))); // R12
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && take_wr && op == OP_SET_MODE) |=> $stable(addr)); // R13

endmodule

// File: rtl/dma_read_mux.sv
module dma_read_mux
  import dma_cmd_pkg::*;
#(
  parameter int NCH = 16,
  parameter int AW  = 24,
  parameter int CW  = 16,
  localparam int CHW = $clog2(NCH)
) (
  input  op_e              op,
  input  logic [2:0]       ptr,
  input  logic [CHW-1:0]   chan,
  input  logic [NCH*AW-1:0] addr_v,
  input  logic [NCH*CW-1:0] count_v,
  input  logic [NCH-1:0]   mask_v,
  input  logic [NCH-1:0]   xen_v,
  input  logic [2:0]       limit,
  output logic [7:0]       rdata
);

  logic [AW-1:0] a_sel;
  logic [CW-1:0] c_sel;
  logic [5:0]    shamt;

  assign a_sel = addr_v[chan*AW +: AW];
  assign c_sel = count_v[chan*CW +: CW];
  assign shamt = {ptr, 3'b000};

  always_comb begin
    rdata = 8'h00;
    if (ptr < limit) begin
      case (op)
        OP_GET_ADDR: rdata = 8'(a_sel >> shamt);
        OP_GET_CNT:  rdata = 8'(c_sel >> shamt);
        OP_GET_STAT: rdata = {5'b0, xen_v[chan], (c_sel == '0), mask_v[chan]};
        default:     rdata = 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/dma_cmd_port_ctrl.sv
module dma_cmd_port_ctrl
  import dma_cmd_pkg::*;
#(
  parameter int NCH = 16,
  parameter int AW  = 24,
  parameter int CW  = 16,
  parameter int PW  = 16,
  localparam int CHW = $clog2(NCH),
  localparam int AB  = AW / 8,
  localparam int CB  = CW / 8,
  localparam int PB  = PW / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [7:0]        cmd_byte,
  input  logic              dat_wr,
  input  logic [7:0]        dat_wdata,
  input  logic              dat_rd,
  output logic [7:0]        dat_rdata,
  input  logic              dec_valid,
  input  logic [CHW-1:0]    dec_chan,
  output logic [NCH-1:0]    xfer_en,
  output logic [NCH*AW-1:0] ch_addr,
  output logic [NCH*CW-1:0] ch_count,
  output logic [NCH*PW-1:0] ch_ioport,
  output logic [NCH*8-1:0]  ch_mode
);

  op_e            op_q;
  logic [CHW-1:0] chan_q;
  logic [CHW-1:0] cmd_chan;
  logic [2:0]     ptr_q;
  logic           wr_ev, rd_ev, mask_ev, unmask_ev, clr_ev;
  logic [NCH-1:0] mask_v;
  logic [2:0]     limit;

  assign limit = param_bytes(op_q, 3'(AB), 3'(CB), 3'(PB));

  dma_cmd_decoder #(.NCH(NCH), .AB(AB), .CB(CB), .PB(PB)) u_dec (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_byte(cmd_byte),
    .dat_wr(dat_wr), .dat_rd(dat_rd), .op_q(op_q), .chan_q(chan_q),
    .ptr_q(ptr_q), .cmd_chan(cmd_chan), .wr_ev(wr_ev), .rd_ev(rd_ev),
    .mask_ev(mask_ev), .unmask_ev(unmask_ev), .clr_ev(clr_ev)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dma_chan_regs #(.AW(AW), .CW(CW), .PW(PW)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .sel_dat(chan_q == CHW'(c)),
      .sel_cmd(cmd_chan == CHW'(c)),
      .op(op_q), .wr_ev(wr_ev), .wr_idx(ptr_q), .wdata(dat_wdata),
      .mask_ev(mask_ev), .unmask_ev(unmask_ev), .clr_ev(clr_ev),
      .dec(dec_valid && dec_chan == CHW'(c)),
      .addr(ch_addr[c*AW +: AW]), .count(ch_count[c*CW +: CW]),
      .ioport(ch_ioport[c*PW +: PW]), .mode(ch_mode[c*8 +: 8]),
      .mask(mask_v[c]), .xen(xfer_en[c])
    );
  end

  dma_read_mux #(.NCH(NCH), .AW(AW), .CW(CW)) u_rmux (
    .op(op_q), .ptr(ptr_q), .chan(chan_q), .addr_v(ch_addr),
    .count_v(ch_count), .mask_v(mask_v), .xen_v(xfer_en),
    .limit(limit), .rdata(dat_rdata)
  );

  AST_CLR_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ev |=> (xfer_en == '0)); // R8
  AST_ONE_DATA_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ev && rd_ev)); // R11
  AST_UNMASK_NO_MODE_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    unmask_ev |=> $stable(ch_mode)); // R7

endmodule

// File: tb/test_dma_cmd_port_ctrl.sv
module test_dma_cmd_port_ctrl;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_wr = 1'b0, dat_wr = 1'b0, dat_rd = 1'b0, dec_valid = 1'b0;
  logic [7:0]   cmd_byte = 8'h00, dat_wdata = 8'h00;
  logic [3:0]   dec_chan = 4'h0;
  logic [7:0]   dat_rdata;
  logic [15:0]  xfer_en;
  logic [383:0] ch_addr;
  logic [255:0] ch_count, ch_ioport;
  logic [127:0] ch_mode;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  dma_cmd_port_ctrl i_dma_cmd_port_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_byte(cmd_byte),
    .dat_wr(dat_wr), .dat_wdata(dat_wdata), .dat_rd(dat_rd), .dat_rdata(dat_rdata),
    .dec_valid(dec_valid), .dec_chan(dec_chan), .xfer_en(xfer_en),
    .ch_addr(ch_addr), .ch_count(ch_count), .ch_ioport(ch_ioport), .ch_mode(ch_mode)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] addr_of(input int c); return 32'(ch_addr[c*24 +: 24]); endfunction
  function automatic logic [31:0] cnt_of(input int c);  return 32'(ch_count[c*16 +: 16]); endfunction
  function automatic logic [31:0] io_of(input int c);   return 32'(ch_ioport[c*16 +: 16]); endfunction
  function automatic logic [31:0] mode_of(input int c); return 32'(ch_mode[c*8 +: 8]); endfunction

  task automatic send_cmd(input logic [7:0] b);
    @(negedge clk); cmd_wr = 1'b1; cmd_byte = b;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic send_dat(input logic [7:0] b);
    @(negedge clk); dat_wr = 1'b1; dat_wdata = b;
    @(negedge clk); dat_wr = 1'b0;
  endtask

  task automatic read_dat(input string req, input logic [7:0] exp);
    @(negedge clk);
    check(req, 32'(dat_rdata), 32'(exp));
    dat_rd = 1'b1;
    @(negedge clk); dat_rd = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 xfer_en", 32'(xfer_en), 0);
    check("R1 modes", 32'(|ch_mode), 0);
    check("R1 addr ch5", addr_of(5), 0);
    check("R1 count ch9", cnt_of(9), 0);
    send_cmd(8'h60);
    read_dat("R1 R10 reset status ch0", 8'h03);
    read_dat("R11 no second status byte", 8'h00);
  endtask

  task automatic t_program;
    send_cmd(8'h93);
    send_cmd(8'h73); send_dat(8'h4C);
    check("R6 mode ch3", mode_of(3), 32'h4C);
    send_cmd(8'h23); send_dat(8'h56); send_dat(8'h34); send_dat(8'h12);
    check("R3 addr ch3", addr_of(3), 32'h123456);
    // 1024 bytes in 16-bit units -> 512 words -> count 511
    send_cmd(8'h43); send_dat(8'hFF); send_dat(8'h01);
    check("R4 count ch3", cnt_of(3), 32'h01FF);
    send_cmd(8'h03); send_dat(8'hF0); send_dat(8'h03);
    check("R5 ioport ch3", io_of(3), 32'h03F0);
    check("R7 masked no enable", 32'(xfer_en[3]), 0);
    send_cmd(8'hA3);
    check("R7 unmasked enable", 32'(xfer_en), 32'h0008);
  endtask

  task automatic t_readback;
    send_cmd(8'h33);
    read_dat("R9 addr b0", 8'h56); read_dat("R9 addr b1", 8'h34);
    read_dat("R9 addr b2", 8'h12); read_dat("R11 addr past end", 8'h00);
    send_cmd(8'h53);
    read_dat("R9 count b0", 8'hFF); read_dat("R9 count b1", 8'h01);
    send_cmd(8'h63);
    read_dat("R10 status ch3", 8'h04);
  endtask

  task automatic t_decrement;
    repeat (2) begin
      @(negedge clk); dec_valid = 1'b1; dec_chan = 4'd3;
      @(negedge clk); dec_valid = 1'b0;
    end
    check("R12 wide count", cnt_of(3), 32'h01FD);
    check("R12 wide addr", addr_of(3), 32'h123452);
    send_cmd(8'h77); send_dat(8'h04);
    send_cmd(8'h27); send_dat(8'h00); send_dat(8'h00); send_dat(8'h00);
    send_cmd(8'h47); send_dat(8'h01); send_dat(8'h00);
    @(negedge clk); dec_valid = 1'b1; dec_chan = 4'd7;
    @(negedge clk); dec_valid = 1'b0;
    check("R12 byte addr wraps", addr_of(7), 32'hFFFFFF);
    check("R12 count to zero", cnt_of(7), 0);
    @(negedge clk); dec_valid = 1'b1; dec_chan = 4'd7;
    @(negedge clk); dec_valid = 1'b0;
    check("R12 zero count holds addr", addr_of(7), 32'hFFFFFF);
    check("R12 zero count holds", cnt_of(7), 0);
  endtask

  task automatic t_ignored;
    send_cmd(8'h77); send_dat(8'h04); send_dat(8'hFF);
    check("R11 extra mode byte ignored", mode_of(7), 32'h04);
    send_cmd(8'h37); send_dat(8'hAA);
    check("R11 write under read ignored", addr_of(7), 32'hFFFFFF);
    read_dat("R11 pointer not moved by write", 8'hFF);
  endtask

  task automatic t_ptr_reset;
    send_cmd(8'h25); send_dat(8'h11);
    send_cmd(8'h25); send_dat(8'h22); send_dat(8'h33); send_dat(8'h44);
    check("R2 command restarts pointer", addr_of(5), 32'h443322);
    @(negedge clk); cmd_wr = 1'b1; cmd_byte = 8'h25; dat_wr = 1'b1; dat_wdata = 8'h99;
    @(negedge clk); cmd_wr = 1'b0; dat_wr = 1'b0;
    send_dat(8'h01); send_dat(8'h02); send_dat(8'h03);
    check("R2 data with command dropped", addr_of(5), 32'h030201);
  endtask

  task automatic t_collision;
    send_cmd(8'h43);
    @(negedge clk); dat_wr = 1'b1; dat_wdata = 8'h10; dec_valid = 1'b1; dec_chan = 4'd3;
    @(negedge clk); dat_wr = 1'b0; dec_valid = 1'b0;
    check("R13 write wins count", cnt_of(3), 32'h0110);
    check("R13 decrement dropped addr", addr_of(3), 32'h123452);
    send_dat(8'h00);
    check("R4 high byte", cnt_of(3), 32'h0010);
  endtask

  task automatic t_clear;
    send_cmd(8'hD0);
    check("R8 enables cleared", 32'(xfer_en), 0);
    check("R8 modes cleared", 32'(|ch_mode), 0);
    check("R8 addr kept", addr_of(3), 32'h123452);
    check("R8 count kept", cnt_of(3), 32'h0010);
    send_cmd(8'h63);
    read_dat("R8 R10 status masked", 8'h01);
    send_cmd(8'hA3);
    check("R7 unmask with mode zero", 32'(xfer_en), 0);
  endtask

  initial begin
    #800000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_readback();
    t_decrement();
    t_ignored();
    t_ptr_reset();
    t_collision();
    t_clear();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule